// File: doc/BRIEF.md
# SDRAM Refresh Interval Scheduler

This block decides when a memory controller owes the SDRAM an auto-refresh command. Every row of the array must be refreshed once per retention window (64 ms), and a full sweep of the array takes a fixed number of refresh commands (4096). The block divides the window by that count at the configured clock rate to get a per-command interval in clock cycles, counts cycles, and adds one owed refresh to a small debt counter at the end of each interval. The controller's command arbiter sees a request while any refresh is owed. It returns a one-cycle grant each time it issues a refresh command, which pays off one unit of debt.

The arbiter may postpone refreshes behind other traffic, but the debt is capped at a fixed depth. An urgent flag tells the arbiter that the cap has been reached and that refresh must now win. A separate self-refresh input moves the block into a state in which the device refreshes itself. Interval counting then stops and requests are withheld. On leaving that state, one refresh is owed at once and a fresh interval begins.

Top module: `refresh_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, `ref_req`, `ref_urgent` and `sr_active` are 0, the debt is zero and the interval count is zero.
- R2: The interval is INTERVAL = floor(CLK_KHZ * PERIOD_MS / ROWS) cycles, which is 2078 for the defaults and 15 for CLK_KHZ = 1000. The first refresh is owed exactly INTERVAL rising edges after reset is released, and one more is owed every INTERVAL edges after that while self refresh is inactive.
- R3: `ref_req` is 1 exactly when the debt is non-zero and self refresh is inactive.
- R4: A `ref_grant` pulse seen at a rising edge while the debt is non-zero lowers the debt by one. A grant with zero debt has no effect, and the debt never wraps below zero.
- R5: The debt saturates at DEBT_MAX (default 8). `ref_urgent` is 1 exactly when the debt equals DEBT_MAX and self refresh is inactive.
- R6: When an interval expires at the same edge as an effective grant, the debt is unchanged.
- R7: `sr_active` follows `sr_req` one edge later. While it is 1, `ref_req` and `ref_urgent` are 0, the interval count is frozen and grants are ignored.
- R8: At the edge where `sr_active` falls, one refresh is added to the debt (saturating at DEBT_MAX) and the interval count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_grant | input | 1 | One-cycle pulse: the arbiter has issued one auto-refresh command |
| sr_req | input | 1 | Level: hold the device in self refresh |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | The debt has reached its cap |
| sr_active | output | 1 | The self-refresh state is in force |

## Verification
Two coincidences matter. The first is an interval expiring at the very edge where a grant lands. It is provoked by counting edges from reset so that the grant pulse covers the expiry edge. It is judged by the request still being high after the grant and falling only after a second grant. The second is leaving self refresh, which adds debt and restarts the interval at the same edge. Its effect is judged by draining the debt with grants and then checking that the next request appears exactly one interval after the exit edge, neither earlier nor later.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic {
        SR_OFF = 1'b0,
        SR_ON  = 1'b1
    } sr_state_t;

    typedef struct packed {
        logic tick;
        logic pay;
        logic wake;
    } debt_ev_t;

    function automatic int calc_interval(input int khz, input int ms, input int rows);
        return (khz * ms) / rows;
    endfunction

endpackage

// File: rtl/sr_tracker.sv
module sr_tracker
    import sched_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sr_req,
    output logic active,
    output logic wake
);
    sr_state_t state;

    always_ff @(posedge clk) begin
        if (rst) state <= SR_OFF;
        else     state <= sr_req ? SR_ON : SR_OFF;
    end

    assign active = (state == SR_ON);
    assign wake   = active && !sr_req;

    assert_follow_R7: assert property (@(posedge clk) disable iff (rst)
        sr_req |=> active);
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int INTERVAL = 2078
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic restart,
    output logic tick
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)     cnt <= '0;
        else if (hold)          cnt <= cnt;
        else if (cnt == LAST)   cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign tick = !hold && (cnt == LAST);

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (!hold && !restart && cnt == LAST) |=> cnt == '0);
    assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (hold && !restart) |=> cnt == $past(cnt));
    assert_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
endmodule

// File: rtl/debt_counter.sv
module debt_counter
    import sched_pkg::*;
#(
    parameter int DEBT_MAX = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  debt_ev_t ev,
    output logic     owed,
    output logic     full
);
    localparam int DW = $clog2(DEBT_MAX + 1);
    localparam logic [DW-1:0] CAP = DW'(DEBT_MAX);

    logic [DW-1:0] debt;
    logic          inc, dec;

    assign inc = ev.tick || ev.wake;
    assign dec = ev.pay && (debt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            debt <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   debt <= (debt == CAP) ? CAP : debt + 1'b1;
                2'b01:   debt <= debt - 1'b1;
                default: debt <= debt;
            endcase
        end
    end

    assign owed = (debt != '0);
    assign full = (debt == CAP);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        debt <= CAP);
    assert_pay_R4: assert property (@(posedge clk) disable iff (rst)
        (ev.pay && !ev.tick && !ev.wake && debt != '0) |=> debt == $past(debt) - 1'b1);
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (debt == '0 && !ev.tick && !ev.wake) |=> debt == '0);
    assert_coincide_R6: assert property (@(posedge clk) disable iff (rst)
        (ev.tick && ev.pay && debt != '0) |=> debt == $past(debt));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import sched_pkg::*;
#(
    parameter int CLK_KHZ   = 133000,
    parameter int PERIOD_MS = 64,
    parameter int ROWS      = 4096,
    parameter int DEBT_MAX  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_grant,
    input  logic sr_req,
    output logic ref_req,
    output logic ref_urgent,
    output logic sr_active
);
    localparam int INTERVAL = calc_interval(CLK_KHZ, PERIOD_MS, ROWS);

    logic     active, wake, tick, owed, full;
    debt_ev_t ev;

    sr_tracker u_sr (
        .clk    (clk),
        .rst    (rst),
        .sr_req (sr_req),
        .active (active),
        .wake   (wake)
    );

    interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .hold    (active),
        .restart (wake),
        .tick    (tick)
    );

    assign ev.tick = tick;
    assign ev.pay  = ref_grant && !active;
    assign ev.wake = wake;

    debt_counter #(.DEBT_MAX(DEBT_MAX)) u_debt (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .owed (owed),
        .full (full)
    );

    assign ref_req    = owed && !active;
    assign ref_urgent = full && !active;
    assign sr_active  = active;

    assert_exit_owes_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(sr_active) |-> ref_req);
    assert_urgent_implies_req_R5: assert property (@(posedge clk) disable iff (rst)
        ref_urgent |-> ref_req);
    assert_quiet_in_sr_R7: assert property (@(posedge clk) disable iff (rst)
        (sr_active && $past(sr_active)) |-> !ref_req);
endmodule

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;
    localparam int KHZ = 1000;
    localparam int EXP_INT = (KHZ * 64) / 4096;   // 15 cycles per interval
    localparam int CAP = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_grant = 1'b0;
    logic sr_req = 1'b0;
    logic ref_req, ref_urgent, sr_active;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    refresh_sched #(.CLK_KHZ(KHZ), .PERIOD_MS(64), .ROWS(4096), .DEBT_MAX(CAP)) dut (
        .clk(clk), .rst(rst), .ref_grant(ref_grant), .sr_req(sr_req),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .sr_active(sr_active)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic grant_pulse();
        ref_grant = 1'b1;
        edges(1);
        ref_grant = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; ref_grant = 1'b0; sr_req = 1'b0;
        edges(2);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; ref_grant = 1'b1; sr_req = 1'b0;
        edges(3);
        check("R1 req in reset", ref_req, 1'b0);
        check("R1 urgent in reset", ref_urgent, 1'b0);
        check("R1 sr_active in reset", sr_active, 1'b0);
        ref_grant = 1'b0;
        rst = 1'b0;
        edges(1);
        check("R1 req after release", ref_req, 1'b0);
    endtask

    task automatic t_interval();
        do_reset();
        edges(EXP_INT - 1);
        check("R2 no req before interval", ref_req, 1'b0);
        edges(1);
        check("R2 req at interval", ref_req, 1'b1);
        check("R3 req not urgent", ref_urgent, 1'b0);
    endtask

    task automatic t_grant();
        do_reset();
        edges(EXP_INT);
        grant_pulse();
        check("R4 grant clears one", ref_req, 1'b0);
        grant_pulse();
        check("R4 grant at zero ignored", ref_req, 1'b0);
        check("R4 no wrap urgent", ref_urgent, 1'b0);
        edges(EXP_INT - 3);
        check("R2 second interval not yet", ref_req, 1'b0);
        edges(1);
        check("R2 second interval", ref_req, 1'b1);
    endtask

    task automatic t_saturate();
        do_reset();
        edges(7 * EXP_INT);
        check("R5 not urgent at 7", ref_urgent, 1'b0);
        check("R3 req at 7", ref_req, 1'b1);
        edges(EXP_INT);
        check("R5 urgent at cap", ref_urgent, 1'b1);
        edges(3 * EXP_INT);
        check("R5 urgent held", ref_urgent, 1'b1);
        grant_pulse();
        check("R5 urgent drops", ref_urgent, 1'b0);
        check("R5 req remains", ref_req, 1'b1);
        for (int i = 0; i < 7; i++) grant_pulse();
        check("R5 saturated at cap", ref_req, 1'b0);
    endtask

    task automatic t_coincide();
        do_reset();
        edges(EXP_INT);
        edges(EXP_INT - 1);
        grant_pulse();
        check("R6 tick plus grant keeps debt", ref_req, 1'b1);
        grant_pulse();
        check("R6 one left", ref_req, 1'b0);
    endtask

    task automatic t_selfref();
        do_reset();
        edges(EXP_INT);
        sr_req = 1'b1;
        edges(1);
        check("R7 sr_active follows", sr_active, 1'b1);
        check("R7 req masked", ref_req, 1'b0);
        grant_pulse();
        edges(5 * EXP_INT);
        check("R7 req masked long", ref_req, 1'b0);
        check("R7 urgent masked", ref_urgent, 1'b0);
        sr_req = 1'b0;
        edges(1);
        check("R7 sr_active drops", sr_active, 1'b0);
        check("R8 req on exit", ref_req, 1'b1);
        grant_pulse();
        check("R8 debt was two", ref_req, 1'b1);
        grant_pulse();
        check("R8 drained", ref_req, 1'b0);
        edges(EXP_INT - 3);
        check("R8 restart not yet", ref_req, 1'b0);
        edges(1);
        check("R8 restart interval", ref_req, 1'b1);
    endtask

    task automatic t_exit_full();
        do_reset();
        edges(8 * EXP_INT);
        check("R5 urgent before sr", ref_urgent, 1'b1);
        sr_req = 1'b1;
        edges(1);
        check("R7 urgent hidden", ref_urgent, 1'b0);
        edges(3);
        sr_req = 1'b0;
        edges(1);
        check("R8 exit saturates", ref_urgent, 1'b1);
        for (int i = 0; i < 8; i++) grant_pulse();
        check("R8 exit no overflow", ref_req, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_interval();
        t_grant();
        t_saturate();
        t_coincide();
        t_selfref();
        t_exit_full();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule